// File: doc/BRIEF.md
# Bipolar Return-to-Zero Word Transmitter

This block takes one 32-bit avionics data word at a time from a parallel ready/valid interface and sends it on a three-level return-to-zero serial line. Each word is given as four fields: an 8-bit label, a 2-bit source/destination identifier, a 19-bit data field and a 2-bit sign/status field. The block adds an odd parity bit and sends the 32 frame bits one after another. The line is shown as two logic outputs: a "high" leg and a "low" leg. Each bit drives one leg for the first half of its bit time, and both legs are low for the second half. The receiver can therefore recover timing from the pulses alone.

Two bit rates are available. Parameters give the number of system clocks in a half bit for each rate, so that the slow rate and the fast rate sit in the ratio of 12.5 kbit/s to 100 kbit/s. The rate input is read only when a word is accepted. After every frame the line stays in the null state for a set number of bit times. A new word is taken in only after that gap has ended.

Top module: `bprz_word_tx`

## Requirements
- R1: After reset, both line legs are low, busy is low and in_ready is high. The line is null whenever busy is low.
- R2: Frame bits go out in order from bit 1 to bit 32. Bits 1 to 8 carry the label with label bit 7 (its MSB) first, so frame bit 1+k is label[7-k].
- R3: Frame bits 9-10 carry in_sdi[0], in_sdi[1]. Bits 11-29 carry in_data[0] to in_data[18]. Bits 30-31 carry in_ssm[0], in_ssm[1]. Each of these fields goes out LSB first.
- R4: Frame bit 32 is chosen so that the 32 transmitted bits contain an odd number of ones.
- R5: A one drives line_hi and a zero drives line_lo, for the first half of the bit time. Both legs are low in the second half, and the two legs are never high together.
- R6: A half bit lasts HALF_FAST clocks when rate_sel was 1 at acceptance and HALF_SLOW clocks when it was 0. The first half of bit 1 begins on the clock edge that accepts the word.
- R7: rate_sel is read only at acceptance. Changing it during a frame does not alter that frame's timing.
- R8: After bit 32 the line stays null for exactly GAP_BITS bit times at the frame's rate before in_ready rises again. in_ready stays low for the whole frame and gap.
- R9: A word is taken when in_valid and in_ready are both high at a clock edge. A word offered while a frame is in progress is held off and sent unchanged once in_ready returns.
- R10: busy is high from the edge after acceptance until the gap ends. Each busy interval carries exactly 32 bit pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is offered on the field inputs |
| in_ready | output | 1 | Block can accept a word (idle) |
| in_label | input | 8 | Label field |
| in_sdi | input | 2 | Source/destination identifier field |
| in_data | input | 19 | Data field |
| in_ssm | input | 2 | Sign/status field |
| rate_sel | input | 1 | 1 selects the fast rate, 0 the slow rate; read at acceptance |
| line_hi | output | 1 | High leg of the bipolar line (pulse for a one) |
| line_lo | output | 1 | Low leg of the bipolar line (pulse for a zero) |
| busy | output | 1 | Frame or inter-word gap in progress |

## Verification
The bound checker enforces these rules on every cycle:
- the two legs are never both high;
- the line is null while the block is idle;
- an accepted word makes the block busy and drops in_ready on the next edge;
- each busy interval carries exactly 32 pulses;
- the pulses of each word hold an odd count of ones.

Some properties can only be shown by the bench scenarios, which compare each frame against expected values:
- the position and order of each field, including the reversed label;
- the half-bit length at both rates;
- the exact gap length;
- that a rate change during a frame is ignored;
- that a word held off during a frame is later sent intact.

// File: rtl/bprz_tx_pkg.sv
`timescale 1ns/1ps
// Package: frame geometry and controller state encoding shared by the
// transmitter modules. Assumes the fixed 32-bit word layout.
package bprz_tx_pkg;
    localparam int FRAME_W = 32;
    localparam int LABEL_W = 8;
    localparam int SDI_W   = 2;
    localparam int DATA_W  = 19;
    localparam int SSM_W   = 2;
    localparam int SDI_LSB  = LABEL_W;
    localparam int DATA_LSB = SDI_LSB + SDI_W;
    localparam int SSM_LSB  = DATA_LSB + DATA_W;
    localparam int PAR_POS  = FRAME_W - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_t;
endpackage

// File: rtl/bprz_frame_pack.sv
`timescale 1ns/1ps
// Module: bprz_frame_pack
// Builds the 32-bit frame in transmit order (index 0 goes out first).
// The label is bit-reversed so that its MSB leads. The other fields
// keep LSB-first order. The top bit is odd parity over the rest.
// Purely combinational; assumes the field widths in bprz_tx_pkg.
module bprz_frame_pack
    import bprz_tx_pkg::*;
(
    input  logic [LABEL_W-1:0] label,
    input  logic [SDI_W-1:0]   sdi,
    input  logic [DATA_W-1:0]  data,
    input  logic [SSM_W-1:0]   ssm,
    output logic [FRAME_W-1:0] frame
);
    // Label reversal: frame slot k carries label bit LABEL_W-1-k.
    for (genvar k = 0; k < LABEL_W; k++) begin : g_label
        assign frame[k] = label[LABEL_W-1-k];
    end

    // Remaining fields sit LSB first in their slots.
    assign frame[DATA_LSB-1:SDI_LSB] = sdi;
    assign frame[SSM_LSB-1:DATA_LSB] = data;
    assign frame[PAR_POS-1:SSM_LSB]  = ssm;

    // Odd parity: the full word must carry an odd number of ones.
    assign frame[PAR_POS] = ~(^frame[PAR_POS-1:0]);
endmodule

// File: rtl/bprz_half_timer.sv
`timescale 1ns/1ps
// Module: bprz_half_timer
// Counts system clocks while run is high. It pulses half_end on the
// last clock of each half-bit period of length half_len. It clears
// while stopped. Assumes half_len >= 1 and stable while running.
module bprz_half_timer #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half_len,
    output logic          half_end
);
    logic [CW-1:0] cnt;

    assign half_end = run && (cnt == half_len - 1'b1);

    // Half-bit clock counter; wraps at each half end, clears when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || half_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bprz_line_enc.sv
`timescale 1ns/1ps
// Module: bprz_line_enc
// Maps the current bit onto the two line legs. While drive is high
// (first half of a bit), a one raises hi and a zero raises lo. Both
// legs are low otherwise. Combinational; inputs come from registers.
module bprz_line_enc (
    input  logic drive,
    input  logic bit_val,
    output logic hi,
    output logic lo
);
    // Three-level return-to-zero leg selection.
    always_comb begin
        hi = drive &  bit_val;
        lo = drive & ~bit_val;
    end
endmodule

// File: rtl/bprz_word_tx.sv
`timescale 1ns/1ps
// Module: bprz_word_tx (top)
// Accepts a field-structured word over ready/valid and builds the
// parity-protected frame. It shifts the frame out on a bipolar
// return-to-zero line, then holds the line null for GAP_BITS bit
// times. rate_sel is latched only when a word is accepted.
// Assumes HALF_FAST >= 1, HALF_SLOW >= 1, GAP_BITS >= 1.
module bprz_word_tx
    import bprz_tx_pkg::*;
#(
    parameter int HALF_FAST = 1000,
    parameter int HALF_SLOW = 8000,
    parameter int GAP_BITS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LABEL_W-1:0] in_label,
    input  logic [SDI_W-1:0]   in_sdi,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [SSM_W-1:0]   in_ssm,
    input  logic               rate_sel,
    output logic               line_hi,
    output logic               line_lo,
    output logic               busy
);
    localparam int MAX_HALF = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int CW       = $clog2(MAX_HALF + 1);
    localparam int MAX_CNT  = (GAP_BITS > FRAME_W) ? GAP_BITS : FRAME_W;
    localparam int NCW      = $clog2(MAX_CNT + 1);

    tx_state_t           state;
    logic [FRAME_W-1:0]  frame;
    logic [FRAME_W-1:0]  shreg;
    logic [CW-1:0]       half_len;
    logic                phase;      // 0: driven half, 1: return-to-zero half
    logic [NCW-1:0]      nbit;       // bit index within frame or gap
    logic                half_end;
    logic                drive;

    bprz_frame_pack u_pack (
        .label (in_label),
        .sdi   (in_sdi),
        .data  (in_data),
        .ssm   (in_ssm),
        .frame (frame)
    );

    bprz_half_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state != ST_IDLE),
        .half_len (half_len),
        .half_end (half_end)
    );

    assign drive = (state == ST_SEND) && !phase;

    bprz_line_enc u_enc (
        .drive   (drive),
        .bit_val (shreg[0]),
        .hi      (line_hi),
        .lo      (line_lo)
    );

    assign in_ready = (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);

    // Sequencer: load on accept, step half bits, run the null gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            half_len <= CW'(HALF_SLOW);
            phase    <= 1'b0;
            nbit     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        shreg    <= frame;
                        half_len <= rate_sel ? CW'(HALF_FAST) : CW'(HALF_SLOW);
                        phase    <= 1'b0;
                        nbit     <= '0;
                        state    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (half_end) begin
                        phase <= ~phase;
                        if (phase) begin
                            shreg <= shreg >> 1;
                            if (nbit == NCW'(FRAME_W - 1)) begin
                                nbit  <= '0;
                                state <= ST_GAP;
                            end else begin
                                nbit <= nbit + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (half_end) begin
                        phase <= ~phase;
                        if (phase) begin
                            if (nbit == NCW'(GAP_BITS - 1)) begin
                                nbit  <= '0;
                                state <= ST_IDLE;
                            end else begin
                                nbit <= nbit + 1'b1;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bprz_tx_chk.sv
`timescale 1ns/1ps
// Module: bprz_tx_chk
// Port-level protocol checker for bprz_word_tx. It watches only the
// line legs and the handshake. It counts pulses and their ones-parity
// per busy interval. Attached to every instance of the top by bind.
module bprz_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic line_hi,
    input logic line_lo,
    input logic busy
);
    logic       prev_act;
    logic [5:0] pcnt;
    logic       par;
    logic       act;
    logic       pstart;

    assign act    = line_hi | line_lo;
    assign pstart = act && !prev_act;

    // Pulse bookkeeping: count pulses and ones per busy interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_act <= 1'b0;
            pcnt     <= '0;
            par      <= 1'b0;
        end else begin
            prev_act <= act;
            if (!busy) begin
                pcnt <= '0;
                par  <= 1'b0;
            end else if (pstart) begin
                pcnt <= pcnt + 1'b1;
                par  <= par ^ line_hi;
            end
        end
    end

    AST_LEGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo)); // R5

    AST_NULL_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_hi && !line_lo)); // R1

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !in_ready)); // R9

    AST_ODD_WORD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (pstart && pcnt == 6'd31) |-> (par ^ line_hi)); // R4

    AST_WORD_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pcnt == 6'd32)); // R10
endmodule

bind bprz_word_tx bprz_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .line_hi  (line_hi),
    .line_lo  (line_lo),
    .busy     (busy)
);

// File: tb/sim_bprz_word_tx.sv
`timescale 1ns/1ps
// Directed bench for bprz_word_tx: one task per scenario, each checking its own results.
module sim_bprz_word_tx;
    localparam int HF  = 2;
    localparam int HS  = 5;
    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_label = '0;
    logic [1:0]  in_sdi = '0;
    logic [18:0] in_data = '0;
    logic [1:0]  in_ssm = '0;
    logic        rate_sel = 1'b1;
    logic        line_hi, line_lo, busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    bprz_word_tx #(.HALF_FAST(HF), .HALF_SLOW(HS), .GAP_BITS(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_label(in_label), .in_sdi(in_sdi), .in_data(in_data), .in_ssm(in_ssm),
        .rate_sel(rate_sel), .line_hi(line_hi), .line_lo(line_lo), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected frame, built slot by slot from the requirement text.
    function automatic logic [31:0] expect_frame(input logic [7:0] lab, input logic [1:0] sdi,
                                                 input logic [18:0] dat, input logic [1:0] ssm);
        logic [31:0] f;
        int ones;
        f = '0;
        for (int k = 0; k < 8; k++) f[k] = lab[7-k];
        f[8] = sdi[0]; f[9] = sdi[1];
        for (int i = 0; i < 19; i++) f[10+i] = dat[i];
        f[29] = ssm[0]; f[30] = ssm[1];
        ones = 0;
        for (int k = 0; k < 31; k++) ones += f[k];
        f[31] = (ones % 2 == 0);
        return f;
    endfunction

    // Offer a word at a falling edge and wait for the accepting edge;
    // return with the bench on the falling edge just after it.
    task automatic offer(input logic [7:0] lab, input logic [1:0] sdi, input logic [18:0] dat,
                         input logic [1:0] ssm, input logic rate, output int waited);
        @(negedge clk);
        in_label = lab; in_sdi = sdi; in_data = dat; in_ssm = ssm;
        rate_sel = rate; in_valid = 1'b1;
        waited = 0;
        while (!in_ready && waited < 100000) begin
            @(negedge clk);
            waited++;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Sample the 32 bits and the gap; called right after the accept edge.
    task automatic observe(input int h, input logic [31:0] exp, input bit flip_rate, input string tag);
        logic [31:0] cap;
        int enc_bad, busy_bad, gap_bad, n;
        bit held;
        cap = '0; enc_bad = 0; busy_bad = 0; gap_bad = 0; held = 1'b0;
        for (int k = 0; k < 32; k++) begin
            if (line_hi && !line_lo) cap[k] = 1'b1;
            else if (!line_hi && line_lo) cap[k] = 1'b0;
            else enc_bad++;
            if (!busy || in_ready) busy_bad++;
            if (k == 0) begin
                repeat (h - 1) @(negedge clk);
                held = line_hi | line_lo;
                @(negedge clk);
            end else begin
                repeat (h) @(negedge clk);
            end
            if (line_hi || line_lo) enc_bad++;
            if (flip_rate && k == 3) rate_sel = ~rate_sel;
            repeat (h) @(negedge clk);
        end
        check(enc_bad == 0, "R5", {tag, " return-to-zero encoding errors"}, enc_bad, 0);
        check(held, "R6", {tag, " first half-bit length"}, {31'd0, held}, 1);
        check(cap[7:0] == exp[7:0], "R2", {tag, " label slots, MSB first"}, cap[7:0], exp[7:0]);
        check(cap[30:8] == exp[30:8], "R3", {tag, " sdi/data/ssm slots, LSB first"}, cap[30:8], exp[30:8]);
        check(cap[31] == exp[31], "R4", {tag, " odd parity bit"}, cap[31], exp[31]);
        check(busy_bad == 0, "R10", {tag, " busy high through frame"}, busy_bad, 0);
        n = 0;
        while (!in_ready && n < 100000) begin
            if (line_hi || line_lo || !busy) gap_bad++;
            @(negedge clk);
            n++;
        end
        check(n == 2 * h * GAP, "R8", {tag, " null gap length in clocks"}, n, 2 * h * GAP);
        check(gap_bad == 0, "R8", {tag, " line null and busy during gap"}, gap_bad, 0);
    endtask

    task automatic t_reset();
        check(!line_hi && !line_lo, "R1", "line null after reset", {line_hi, line_lo}, 0);
        check(!busy, "R1", "busy low after reset", busy, 0);
        check(in_ready, "R1", "ready high after reset", in_ready, 1);
    endtask

    task automatic t_word(input logic [7:0] lab, input logic [1:0] sdi, input logic [18:0] dat,
                          input logic [1:0] ssm, input logic rate, input string tag);
        int w;
        offer(lab, sdi, dat, ssm, rate, w);
        observe(rate ? HF : HS, expect_frame(lab, sdi, dat, ssm), 1'b0, tag);
    endtask

    // R7: rate flipped mid-frame must not change timing.
    task automatic t_rate_change_mid_frame();
        int w;
        offer(8'h5A, 2'b10, 19'h2A5C3, 2'b01, 1'b1, w);
        observe(HF, expect_frame(8'h5A, 2'b10, 19'h2A5C3, 2'b01), 1'b1, "R7 midframe");
        rate_sel = 1'b1;
    endtask

    // R9: second word offered during the first is held off, then sent intact.
    task automatic t_holdoff();
        int w;
        offer(8'hC3, 2'b11, 19'h7FFFF, 2'b11, 1'b1, w);
        offer(8'h81, 2'b01, 19'h12345, 2'b10, 1'b1, w);
        check(w == 64 * HF + 2 * HF * GAP - 1, "R9", "hold-off cycles before ready",
              w, 64 * HF + 2 * HF * GAP - 1);
        observe(HF, expect_frame(8'h81, 2'b01, 19'h12345, 2'b10), 1'b0, "R9 held word");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word(8'hB0, 2'b01, 19'h0F0F1, 2'b11, 1'b1, "fast mixed");
        t_word(8'h00, 2'b00, 19'h00000, 2'b00, 1'b1, "all zero");
        t_word(8'hFF, 2'b11, 19'h7FFFF, 2'b11, 1'b1, "all one");
        t_word(8'h01, 2'b10, 19'h40001, 2'b01, 1'b0, "slow R6");
        t_rate_change_mid_frame();
        t_holdoff();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule